// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This is a purely combinational datapath slice for the prefixed bit-manipulation group of a small 8-bit processor. The decoder presents one operand byte, a 4-bit operation code, a bit index and the current flag nibble. Within the same cycle the unit returns the transformed byte, the next flag nibble and a writeback enable. The enable tells the register file or memory port whether the result must be stored.

Every operation acts on the operand it is given and never on an implicit accumulator. The operations are four rotates (circular and through carry, in both directions), three shifts (arithmetic left, arithmetic right, logical right), a nibble exchange and the three single-bit operations (test, set, clear). Operand width is a parameter that must be even and at least 2. Flags pass through unchanged wherever an operation does not define them.

Top module: `rsb_unit`

## Requirements
- R1: Flag nibble layout on `flags_in` and `flags_out` is bit 3 zero (Z), bit 2 subtract (N), bit 1 half-carry (H), bit 0 carry (C). For every rotate, shift and swap (codes 0 to 7), Z is set exactly when the result is 0, N and H are cleared, and `wr_en` is 1.
- R2: Code 0, circular left: result is the operand rotated left by one with the old bit 7 in bit 0. C takes the old bit 7.
- R3: Code 1, circular right: result is the operand rotated right by one with the old bit 0 in bit 7. C takes the old bit 0.
- R4: Code 2 rotates left through carry: the old C enters bit 0 and the old bit 7 goes to C. Code 3 rotates right through carry: the old C enters bit 7 and the old bit 0 goes to C.
- R5: Code 4, arithmetic left shift: 0 enters bit 0 and the old bit 7 goes to C.
- R6: Code 5, arithmetic right shift, keeps bit 7. Code 7, logical right shift, puts 0 in bit 7. Both move the old bit 0 into C.
- R7: Code 6 exchanges bits [7:4] with bits [3:0] and clears C.
- R8: Code 8, bit test: Z is set when operand bit `bit_idx` is 0, N is cleared, H is set and C is unchanged. `wr_en` is 0 and the result equals the operand.
- R9: Code 9 clears operand bit `bit_idx` and code 10 sets it. All other bits are kept, `flags_out` equals `flags_in`, and `wr_en` is 1.
- R10: Codes 11 to 15 are undefined. The result equals the operand, `flags_out` equals `flags_in`, and `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | DATA_W | Byte to transform |
| bit_idx | input | clog2(DATA_W) | Bit position for codes 8 to 10 |
| op_sel | input | 4 | Operation code |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| result | output | DATA_W | Transformed byte |
| flags_out | output | 4 | Next flags {Z,N,H,C} |
| wr_en | output | 1 | Result must be written back |

## Verification
The unit has no registers, so every output is due in the same cycle its inputs change, zero clock edges later. The bench applies each vector on the falling edge of the 250 MHz clock and samples one nanosecond later, before the next rising edge. The sweep covers all 16 codes and all 256 operand values. It uses four carry/zero input combinations for the shift group and all eight bit indices for the single-bit group.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

   typedef enum logic [3:0] {
      OP_ROLC  = 4'd0,
      OP_RORC  = 4'd1,
      OP_ROLT  = 4'd2,
      OP_RORT  = 4'd3,
      OP_SHLA  = 4'd4,
      OP_SHRA  = 4'd5,
      OP_NSWP  = 4'd6,
      OP_SHRL  = 4'd7,
      OP_BTST  = 4'd8,
      OP_BCLR  = 4'd9,
      OP_BSET  = 4'd10
   } rsb_op_e;

   localparam int FLG_Z = 3;
   localparam int FLG_N = 2;
   localparam int FLG_H = 1;
   localparam int FLG_C = 0;

endpackage

// File: rtl/rsb_shift_rot.sv
module rsb_shift_rot #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] din,
   input  logic [3:0]        op,
   input  logic              cin,
   output logic [DATA_W-1:0] dout,
   output logic              cout
);
   import rsb_pkg::*;

   localparam int HALF_W = DATA_W / 2;
   localparam int MSB    = DATA_W - 1;

   always_comb begin
      dout = din;
      cout = cin;
      case (rsb_op_e'(op))
         OP_ROLC: begin dout = {din[MSB-1:0], din[MSB]}; cout = din[MSB]; end
         OP_RORC: begin dout = {din[0], din[MSB:1]};     cout = din[0];   end
         OP_ROLT: begin dout = {din[MSB-1:0], cin};      cout = din[MSB]; end
         OP_RORT: begin dout = {cin, din[MSB:1]};        cout = din[0];   end
         OP_SHLA: begin dout = {din[MSB-1:0], 1'b0};     cout = din[MSB]; end
         OP_SHRA: begin dout = {din[MSB], din[MSB:1]};   cout = din[0];   end
         OP_NSWP: begin dout = {din[HALF_W-1:0], din[MSB:HALF_W]}; cout = 1'b0; end
         OP_SHRL: begin dout = {1'b0, din[MSB:1]};       cout = din[0];   end
         default: begin dout = din; cout = cin; end
      endcase
   end

   // R6: right shifts must move the old low bit out to carry
   always_comb begin
      if (op == 4'd5 || op == 4'd7)
         p_rshift_carry_r6: assert (cout == din[0]);
   end

endmodule

// File: rtl/rsb_bit_ops.sv
module rsb_bit_ops #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic [DATA_W-1:0] din,
   input  logic [IDX_W-1:0]  idx,
   input  logic              set_bit,
   output logic [DATA_W-1:0] dout,
   output logic              sel_val
);
   logic [DATA_W-1:0] pos_hot;

   for (genvar g = 0; g < DATA_W; g++) begin : g_dec
      assign pos_hot[g] = (idx == IDX_W'(g));
   end

   assign dout    = set_bit ? (din | pos_hot) : (din & ~pos_hot);
   assign sel_val = |(din & pos_hot);

   // R9: exactly one bit position is addressed
   always_comb begin
      p_onehot_sel_r9: assert ($onehot0(pos_hot) && (pos_hot != '0));
   end

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit #(
   parameter int DATA_W = 8,
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic [DATA_W-1:0] operand,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic [3:0]        op_sel,
   input  logic [3:0]        flags_in,
   output logic [DATA_W-1:0] result,
   output logic [3:0]        flags_out,
   output logic              wr_en
);
   import rsb_pkg::*;

   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("rsb_unit: DATA_W must be even and at least 2");
   end

   logic [DATA_W-1:0] sr_res;
   logic              sr_c;
   logic [DATA_W-1:0] bo_res;
   logic              bo_val;

   rsb_shift_rot #(.DATA_W(DATA_W)) u_sr (
      .din  (operand),
      .op   (op_sel),
      .cin  (flags_in[FLG_C]),
      .dout (sr_res),
      .cout (sr_c)
   );

   rsb_bit_ops #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bo (
      .din     (operand),
      .idx     (bit_idx),
      .set_bit (op_sel == OP_BSET),
      .dout    (bo_res),
      .sel_val (bo_val)
   );

   always_comb begin
      result    = operand;
      flags_out = flags_in;
      wr_en     = 1'b0;
      if (!op_sel[3]) begin
         result           = sr_res;
         flags_out[FLG_Z] = (sr_res == '0);
         flags_out[FLG_N] = 1'b0;
         flags_out[FLG_H] = 1'b0;
         flags_out[FLG_C] = sr_c;
         wr_en            = 1'b1;
      end else begin
         case (op_sel)
            OP_BTST: begin
               flags_out[FLG_Z] = ~bo_val;
               flags_out[FLG_N] = 1'b0;
               flags_out[FLG_H] = 1'b1;
            end
            OP_BCLR, OP_BSET: begin
               result = bo_res;
               wr_en  = 1'b1;
            end
            default: ;
         endcase
      end
   end

   // Checks on the merged outputs against the inputs
   always_comb begin
      if (!op_sel[3]) begin
         p_nh_clear_r1: assert (flags_out[FLG_N] == 1'b0 && flags_out[FLG_H] == 1'b0 && wr_en);
      end
      if (op_sel == 4'd8) begin
         p_test_nowb_r8: assert (!wr_en && result == operand && flags_out[FLG_C] == flags_in[FLG_C]);
      end
      if (op_sel == 4'd9 || op_sel == 4'd10) begin
         p_bit_flags_r9: assert (flags_out == flags_in && wr_en);
      end
      if (op_sel > 4'd10) begin
         p_undef_pass_r10: assert (!wr_en && result == operand && flags_out == flags_in);
      end
   end

endmodule

// File: tb/rsb_unit_tb.sv
module rsb_unit_tb;
   logic       clk = 1'b0;
   logic [7:0] operand;
   logic [2:0] bit_idx;
   logic [3:0] op_sel;
   logic [3:0] flags_in;
   logic [7:0] result;
   logic [3:0] flags_out;
   logic       wr_en;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   rsb_unit #(.DATA_W(8)) u_dut (
      .operand   (operand),
      .bit_idx   (bit_idx),
      .op_sel    (op_sel),
      .flags_in  (flags_in),
      .result    (result),
      .flags_out (flags_out),
      .wr_en     (wr_en)
   );

   function automatic string req_of(int op);
      case (op)
         0: return "R2";
         1: return "R3";
         2, 3: return "R4";
         4: return "R5";
         5, 7: return "R6";
         6: return "R7";
         8: return "R8";
         9, 10: return "R9";
         default: return "R10";
      endcase
   endfunction

   // Reference computed arithmetically from the requirements
   task automatic model(input int op, input int a, input int b, input int f,
                        output int r, output int fo, output int w);
      int c, z, p2;
      c  = f % 2;
      z  = (f / 8) % 2;
      p2 = 1;
      for (int k = 0; k < b; k++) p2 = p2 * 2;
      r = a; fo = f; w = 0;
      case (op)
         0: begin r = (a * 2) % 256 + a / 128; c = a / 128; end
         1: begin r = a / 2 + (a % 2) * 128;   c = a % 2;   end
         2: begin r = (a * 2) % 256 + c;       c = a / 128; end
         3: begin r = a / 2 + c * 128;         c = a % 2;   end
         4: begin r = (a * 2) % 256;           c = a / 128; end
         5: begin r = a / 2 + (a / 128) * 128; c = a % 2;   end
         6: begin r = (a % 16) * 16 + a / 16;  c = 0;       end
         7: begin r = a / 2;                   c = a % 2;   end
         default: ;
      endcase
      if (op < 8) begin
         fo = (r == 0 ? 8 : 0) + c;
         w  = 1;
      end else if (op == 8) begin
         z  = ((a / p2) % 2 == 0) ? 1 : 0;
         fo = z * 8 + 2 + c;
      end else if (op == 9) begin
         r = ((a / p2) % 2 == 1) ? a - p2 : a;
         w = 1;
      end else if (op == 10) begin
         r = ((a / p2) % 2 == 0) ? a + p2 : a;
         w = 1;
      end
   endtask

   task automatic apply(input int op, input int a, input int b, input int f);
      int er, ef, ew;
      @(negedge clk);
      op_sel   = 4'(op);
      operand  = 8'(a);
      bit_idx  = 3'(b);
      flags_in = 4'(f);
      #1;
      model(op, a, b, f, er, ef, ew);
      n_tests++;
      if (result !== 8'(er) || flags_out !== 4'(ef) || wr_en !== 1'(ew)) begin
         n_fail++;
         $display("FAIL %s (R1 flags) op=%0d a=%02h b=%0d f=%h: got r=%02h f=%h w=%b exp r=%02h f=%h w=%0d",
                  req_of(op), op, a, b, f, result, flags_out, wr_en, er, ef, ew);
      end
   endtask

   initial begin
      op_sel = '0; operand = '0; bit_idx = '0; flags_in = '0;
      // Reset-state check: zero operand, circular left, R1 sets Z
      apply(0, 0, 0, 0);
      for (int op = 0; op < 16; op++) begin
         for (int a = 0; a < 256; a++) begin
            if (op >= 8 && op <= 10) begin
               for (int b = 0; b < 8; b++) begin
                  apply(op, a, b, (a % 2 == 0) ? 4'hF : 4'h0);
                  apply(op, a, b, (b % 2 == 0) ? 4'h6 : 4'h9);
               end
            end else begin
               apply(op, a, a % 8, 4'h0);
               apply(op, a, a % 8, 4'h1);
               apply(op, a, a % 8, 4'h8);
               apply(op, a, a % 8, 4'hF);
            end
         end
      end
      done = 1'b1;
   end

   initial begin
      for (int cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule